// File: doc/BRIEF.md
# Floating-Point NaN Classifier and Quieter

This block examines one floating-point operand and says what kind of not-a-number it is, if any. The operand sits right-aligned on a 64-bit bus, and a 2-bit code names its format: half, bfloat16, single or double. The block has no clock and no state. Every output is a combinational function of the present inputs. A surrounding floating-point datapath uses it three ways. It screens operands for NaNs. It turns a signaling NaN into its quiet form before passing it on. It supplies the canonical NaN to return when an operation has no NaN operand to propagate.

Two static configuration inputs adjust the encoding rules. The first, `snan_pol`, picks which value of the fraction's top bit marks a signaling NaN. The second, `snan_off`, turns off signaling NaNs altogether, so that every NaN is treated as quiet.

Internally there is one classification lane for each format. The lanes are built by a generate loop from per-format exponent and fraction widths. An output selector then forwards the lane that the format code names. The block has no states and no transitions, so the only "mode" is the combination of format code and the two configuration inputs.

Top module: `fp_nan_unit`

## Requirements
- R1: Format code 0 is half precision: sign bit 15, exponent bits 14:10, fraction bits 9:0. Code 1 is bfloat16: exponent bits 14:7, fraction bits 6:0. Code 2 is single precision: exponent bits 30:23, fraction bits 22:0. Code 3 is double precision: exponent bits 62:52, fraction bits 51:0. `nan_any` is 1 exactly when the exponent field is all ones and the fraction is non-zero.
- R2: With `snan_off`=0 and `snan_pol`=0, `nan_quiet` is 1 when the exponent is all ones and the fraction top bit is 1. `nan_signal` is 1 when the exponent is all ones, the fraction top bit is 0 and the remaining fraction bits are non-zero.
- R3: With `snan_off`=0 and `snan_pol`=1, `nan_signal` is 1 when the exponent is all ones and the fraction top bit is 1. `nan_quiet` is 1 when the exponent is all ones, the fraction top bit is 0 and the remaining fraction bits are non-zero.
- R4: With `snan_off`=1, `nan_signal` is always 0 and `nan_quiet` equals `nan_any`, whatever `snan_pol` is.
- R5: For a signaling NaN under `snan_pol`=0, `quieted_out` is the operand with the fraction top bit set.
- R6: For a signaling NaN under `snan_pol`=1, `quieted_out` is the operand with the fraction top bit cleared and the next lower fraction bit set.
- R7: For any operand that is not a signaling NaN, `quieted_out` equals the operand within the selected format's width.
- R8: `default_nan` has sign 0 and an all-ones exponent. Under `snan_pol`=0 only the fraction top bit is set. Under `snan_pol`=1 every fraction bit except the top one is set.
- R9: Operand bits above the selected format's width have no effect on any output. Bits of `quieted_out` and `default_nan` above that width are 0.
- R10: `nan_quiet` and `nan_signal` are never both 1. Exactly one of them is 1 whenever `nan_any` is 1, and neither is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fmt_sel | input | 2 | Format code: 0 half, 1 bfloat16, 2 single, 3 double |
| operand_in | input | 64 | Operand, right-aligned |
| snan_pol | input | 1 | 0: fraction top bit set means quiet; 1: set means signaling |
| snan_off | input | 1 | 1: no NaN is signaling |
| nan_any | output | 1 | Operand is a NaN of either kind |
| nan_quiet | output | 1 | Operand is a quiet NaN |
| nan_signal | output | 1 | Operand is a signaling NaN |
| quieted_out | output | 64 | Operand with a signaling NaN made quiet, zero above the format width |
| default_nan | output | 64 | Canonical NaN for the format and polarity, zero above the format width |

## Verification
The bench goes after the encodings that sit right on the class boundaries:
- **Fraction top bit set, rest zero.** Under polarity 1 this is a signaling NaN. A design that demanded a non-zero tail for the signaling case would call it an infinity.
- **Top bit clear, only the lowest fraction bit set.** This is the smallest NaN. A design that looked only at the top bit would take it for a quiet NaN, or for no NaN at all.
- **Infinities of both signs.** A design that tested only the exponent would report them as NaNs.
- **Quieting under polarity 1.** A design that forgot to set the next bit would turn the NaN into an infinity.
- **Junk above the format width.** A design that did not mask the upper bits would leak that junk into its outputs or flags.

All 65536 encodings of both 16-bit formats are swept, and random plus directed encodings exercise the wider formats. Every format is run under every combination of polarity and disable input.

// File: rtl/fp_nan_pkg.sv
`timescale 1ns/1ps
package fp_nan_pkg;

    localparam int BUS_W   = 64;
    localparam int NUM_FMT = 4;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_BF16   = 2'd1,
        FMT_SINGLE = 2'd2,
        FMT_DOUBLE = 2'd3
    } fmt_e;

    // exponent width of each format code (R1)
    function automatic int fmt_exp_w(input int code);
        case (code)
            0:       return 5;
            1:       return 8;
            2:       return 8;
            default: return 11;
        endcase
    endfunction

    // fraction width of each format code (R1)
    function automatic int fmt_frac_w(input int code);
        case (code)
            0:       return 10;
            1:       return 7;
            2:       return 23;
            default: return 52;
        endcase
    endfunction

endpackage

// File: rtl/fp_nan_lane.sv
`timescale 1ns/1ps
module fp_nan_lane #(
    parameter int BUS_W  = 64,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [BUS_W-1:0] op_in,
    input  logic             pol_in,
    input  logic             off_in,
    output logic             any_out,
    output logic             quiet_out,
    output logic             signal_out,
    output logic [BUS_W-1:0] quieted_word,
    output logic [BUS_W-1:0] canon_word
);
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int TOP_POS = FRAC_W - 1;

    logic [WORD_W-1:0] word;
    logic              exp_full;
    logic              top_bit;
    logic              tail_nz;
    logic [WORD_W-1:0] qword;
    logic [WORD_W-1:0] dword;

    // only the format's own bits take part (R9)
    assign word     = op_in[WORD_W-1:0];
    assign exp_full = &word[WORD_W-2:FRAC_W];
    assign top_bit  = word[TOP_POS];
    assign tail_nz  = |word[TOP_POS-1:0];

    // classification (R1, R2, R3, R4)
    always_comb begin
        any_out = exp_full & (top_bit | tail_nz);
        if (off_in) begin
            quiet_out  = any_out;
            signal_out = 1'b0;
        end else if (!pol_in) begin
            quiet_out  = exp_full & top_bit;
            signal_out = exp_full & ~top_bit & tail_nz;
        end else begin
            quiet_out  = exp_full & ~top_bit & tail_nz;
            signal_out = exp_full & top_bit;
        end
    end

    // quieting of signaling NaNs, pass-through otherwise (R5, R6, R7)
    always_comb begin
        qword = word;
        if (signal_out) begin
            if (!pol_in) begin
                qword[TOP_POS] = 1'b1;
            end else begin
                qword[TOP_POS]   = 1'b0;
                qword[TOP_POS-1] = 1'b1;
            end
        end
    end

    // canonical NaN (R8)
    always_comb begin
        dword                     = '0;
        dword[WORD_W-2:FRAC_W]    = '1;
        if (!pol_in) begin
            dword[TOP_POS]        = 1'b1;
        end else begin
            dword[TOP_POS-1:0]    = '1;
        end
    end

    // zero extension above the format width (R9)
    assign quieted_word = BUS_W'(qword);
    assign canon_word   = BUS_W'(dword);

endmodule

// File: rtl/fp_nan_sel.sv
`timescale 1ns/1ps
module fp_nan_sel
    import fp_nan_pkg::*;
#(
    parameter int BUS_W   = 64,
    parameter int NUM_FMT = 4
) (
    input  fmt_e                          fmt_in,
    input  logic [NUM_FMT-1:0]            any_vec,
    input  logic [NUM_FMT-1:0]            quiet_vec,
    input  logic [NUM_FMT-1:0]            signal_vec,
    input  logic [NUM_FMT-1:0][BUS_W-1:0] qword_vec,
    input  logic [NUM_FMT-1:0][BUS_W-1:0] canon_vec,
    output logic                          any_o,
    output logic                          quiet_o,
    output logic                          signal_o,
    output logic [BUS_W-1:0]              qword_o,
    output logic [BUS_W-1:0]              canon_o
);
    logic [1:0] idx;

    always_comb begin
        unique case (fmt_in)
            FMT_HALF:   idx = 2'd0;
            FMT_BF16:   idx = 2'd1;
            FMT_SINGLE: idx = 2'd2;
            FMT_DOUBLE: idx = 2'd3;
            default:    idx = 2'd0;
        endcase
    end

    assign any_o    = any_vec[idx];
    assign quiet_o  = quiet_vec[idx];
    assign signal_o = signal_vec[idx];
    assign qword_o  = qword_vec[idx];
    assign canon_o  = canon_vec[idx];

endmodule

// File: rtl/fp_nan_unit.sv
`timescale 1ns/1ps
module fp_nan_unit
    import fp_nan_pkg::*;
(
    input  logic [1:0]  fmt_sel,
    input  logic [63:0] operand_in,
    input  logic        snan_pol,
    input  logic        snan_off,
    output logic        nan_any,
    output logic        nan_quiet,
    output logic        nan_signal,
    output logic [63:0] quieted_out,
    output logic [63:0] default_nan
);
    logic [NUM_FMT-1:0]            any_vec;
    logic [NUM_FMT-1:0]            quiet_vec;
    logic [NUM_FMT-1:0]            signal_vec;
    logic [NUM_FMT-1:0][BUS_W-1:0] qword_vec;
    logic [NUM_FMT-1:0][BUS_W-1:0] canon_vec;

    // one lane per format, widths from the package (R1)
    for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
        fp_nan_lane #(
            .BUS_W  (BUS_W),
            .EXP_W  (fmt_exp_w(g)),
            .FRAC_W (fmt_frac_w(g))
        ) i_lane (
            .op_in        (operand_in),
            .pol_in       (snan_pol),
            .off_in       (snan_off),
            .any_out      (any_vec[g]),
            .quiet_out    (quiet_vec[g]),
            .signal_out   (signal_vec[g]),
            .quieted_word (qword_vec[g]),
            .canon_word   (canon_vec[g])
        );
    end

    fp_nan_sel #(
        .BUS_W   (BUS_W),
        .NUM_FMT (NUM_FMT)
    ) i_sel (
        .fmt_in     (fmt_e'(fmt_sel)),
        .any_vec    (any_vec),
        .quiet_vec  (quiet_vec),
        .signal_vec (signal_vec),
        .qword_vec  (qword_vec),
        .canon_vec  (canon_vec),
        .any_o      (nan_any),
        .quiet_o    (nan_quiet),
        .signal_o   (nan_signal),
        .qword_o    (quieted_out),
        .canon_o    (default_nan)
    );

endmodule

// File: rtl/fp_nan_unit_chk.sv
`timescale 1ns/1ps
module fp_nan_unit_chk (
    input logic [1:0]  fmt_sel,
    input logic [63:0] operand_in,
    input logic        snan_pol,
    input logic        snan_off,
    input logic        nan_any,
    input logic        nan_quiet,
    input logic        nan_signal,
    input logic [63:0] quieted_out,
    input logic [63:0] default_nan
);
    logic [63:0] width_mask;

    always_comb begin
        case (fmt_sel)
            2'd0, 2'd1: width_mask = 64'h0000_0000_0000_FFFF;
            2'd2:       width_mask = 64'h0000_0000_FFFF_FFFF;
            default:    width_mask = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    end

    always_comb begin
        // R10
        excl_flags_chk: assert (!(nan_quiet && nan_signal))
            else $error("quiet and signal both set");
        // R10
        class_cover_chk: assert (nan_any == (nan_quiet || nan_signal))
            else $error("NaN class does not cover nan_any");
        // R4
        off_no_signal_chk: assert (!(snan_off && nan_signal))
            else $error("signal reported while disabled");
        // R7
        pass_through_chk: assert (nan_signal || quieted_out == (operand_in & width_mask))
            else $error("non-signaling operand altered");
        // R9
        upper_zero_chk: assert (((quieted_out | default_nan) & ~width_mask) == 64'd0)
            else $error("bits above format width driven");
        // R8
        default_is_nan_chk: assert (default_nan != 64'd0)
            else $error("default NaN empty");
    end

endmodule

bind fp_nan_unit fp_nan_unit_chk i_fp_nan_unit_chk (
    .fmt_sel     (fmt_sel),
    .operand_in  (operand_in),
    .snan_pol    (snan_pol),
    .snan_off    (snan_off),
    .nan_any     (nan_any),
    .nan_quiet   (nan_quiet),
    .nan_signal  (nan_signal),
    .quieted_out (quieted_out),
    .default_nan (default_nan)
);

// File: tb/test_fp_nan_unit.sv
`timescale 1ns/1ps
module test_fp_nan_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic [63:0] operand_in = 64'd0;
    logic        snan_pol = 1'b0;
    logic        snan_off = 1'b0;
    logic        nan_any, nan_quiet, nan_signal;
    logic [63:0] quieted_out, default_nan;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    fp_nan_unit i_fp_nan_unit (
        .fmt_sel     (fmt_sel),
        .operand_in  (operand_in),
        .snan_pol    (snan_pol),
        .snan_off    (snan_off),
        .nan_any     (nan_any),
        .nan_quiet   (nan_quiet),
        .nan_signal  (nan_signal),
        .quieted_out (quieted_out),
        .default_nan (default_nan)
    );

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s fmt=%0d op=%h pol=%0b off=%0b: actual %h expected %h",
                     tag, fmt_sel, operand_in, snan_pol, snan_off, act, exp);
        end
    endtask

    // expected values straight from the requirements
    task automatic expect_for(input logic [1:0] f, input logic [63:0] op,
                              input logic p, input logic o,
                              output logic a, output logic q, output logic s,
                              output logic [63:0] qo, output logic [63:0] dn,
                              output logic [63:0] m);
        int e, fr, w;
        logic [63:0] x, ex, emax, rest, tb;
        logic ones, top;
        case (f)
            2'd0: begin e = 5;  fr = 10; end  // R1
            2'd1: begin e = 8;  fr = 7;  end
            2'd2: begin e = 8;  fr = 23; end
            default: begin e = 11; fr = 52; end
        endcase
        w    = 1 + e + fr;
        m    = (w == 64) ? ~64'd0 : ((64'd1 << w) - 64'd1);
        x    = op & m;                               // R9
        emax = (64'd1 << e) - 64'd1;
        ex   = (x >> fr) & emax;
        tb   = 64'd1 << (fr - 1);
        top  = (x & tb) != 0;
        rest = x & (tb - 64'd1);
        ones = (ex == emax);
        a    = ones && (top || rest != 0);
        if (o) begin q = a; s = 1'b0; end            // R4
        else if (!p) begin q = ones && top; s = ones && !top && rest != 0; end  // R2
        else begin q = ones && !top && rest != 0; s = ones && top; end          // R3
        qo = x;
        if (s) qo = p ? ((x & ~tb) | (tb >> 1)) : (x | tb);  // R5, R6
        dn = (emax << fr) | (p ? (tb - 64'd1) : tb);        // R8
    endtask

    task automatic run_vec(input logic [1:0] f, input logic [63:0] op,
                           input logic p, input logic o);
        logic a, q, s;
        logic [63:0] qo, dn, m;
        fmt_sel = f; operand_in = op; snan_pol = p; snan_off = o;
        expect_for(f, op, p, o, a, q, s, qo, dn, m);
        #0.5;
        check("R1", {63'd0, nan_any}, {63'd0, a});
        check(o ? "R4" : (p ? "R3" : "R2"), {62'd0, nan_quiet, nan_signal}, {62'd0, q, s});
        check(s ? (p ? "R6" : "R5") : "R7", quieted_out & m, qo);
        check("R8", default_nan & m, dn);
        check("R9", (quieted_out | default_nan) & ~m, 64'd0);
        check("R10", {63'd0, nan_quiet & nan_signal}, 64'd0);
        #0.5;
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        #(190000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [63:0] r;
        void'($urandom(32'h1DEA_5EED));
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #0.2;
        // reset-time state: zero operand is no NaN (R1)
        #0.5;
        check("R1", {61'd0, nan_any, nan_quiet, nan_signal}, 64'd0);
        #0.5;

        // directed corners for every format and configuration
        for (int c = 0; c < 4; c++) begin
            for (int f = 0; f < 4; f++) begin
                int fr;
                fr = (f == 0) ? 10 : (f == 1) ? 7 : (f == 2) ? 23 : 52;
                r = (f == 0) ? 64'h7C00 : (f == 1) ? 64'h7F80 :
                    (f == 2) ? 64'h7F80_0000 : 64'h7FF0_0000_0000_0000;
                run_vec(2'(f), r, c[0], c[1]);                                  // +inf
                run_vec(2'(f), r | (64'd1 << ((f == 3) ? 63 : (f == 2) ? 31 : 15)), c[0], c[1]); // -inf
                run_vec(2'(f), r | 64'd1, c[0], c[1]);                          // smallest NaN
                run_vec(2'(f), r | (64'd1 << (fr - 1)), c[0], c[1]);            // top bit only (R3)
                run_vec(2'(f), r | (64'd1 << (fr - 2)), c[0], c[1]);
                run_vec(2'(f), r | ((64'd1 << fr) - 64'd1), c[0], c[1]);
                run_vec(2'(f), 64'hDEAD_BEEF_0000_0000 & ~((f == 3) ? ~64'd0 : 64'd0), c[0], c[1]); // R9 junk only
            end
        end

        // exhaustive sweep of both 16-bit formats with junk above (R9)
        for (int c = 0; c < 4; c++) begin
            for (int f = 0; f < 2; f++) begin
                for (int v = 0; v < 65536; v++) begin
                    r = {rnd64()} << 16;
                    run_vec(2'(f), r | 64'(v), c[0], c[1]);
                end
            end
        end

        // random single and double, biased towards all-ones exponents
        for (int c = 0; c < 4; c++) begin
            for (int f = 2; f < 4; f++) begin
                for (int k = 0; k < 2000; k++) begin
                    r = rnd64();
                    if ($urandom_range(0, 1) == 1)
                        r = r | ((f == 2) ? 64'h7F80_0000 : 64'h7FF0_0000_0000_0000);
                    if ($urandom_range(0, 3) == 0)
                        r = r & ((f == 2) ? 64'hFFFF_FFFF_FFC0_0000 : 64'hFFF8_0000_0000_0000);
                    run_vec(2'(f), r, c[0], c[1]);
                end
            end
        end

        report();
    end

endmodule